// File: doc/BRIEF.md
# Stacked Flash Region Decoder

This block sits between a memory-mapped read path and a set of four attached flash devices. The devices hang off two ports with two chip selects each. Software gives each device a size in kilobytes. The decoder then places the devices one above the other, starting at address zero. Each device's window begins where the window of the device below it ends, so no base address is ever programmed. A device whose size is zero takes no address space and is passed over.

For each incoming read address the block reports three results: which chip select owns the address, the byte offset inside that device, and whether the address falls above every configured window. The lookup itself is combinational. All three results are captured in one output register stage, so a result appears on the cycle after its request.

Top module: `flash_region_decode`

## Requirements
- R1: After reset all four size registers hold zero and `rsp_valid` is low, so any request made before configuration returns `rsp_miss` high.
- R2: A write with `cfg_we` high stores `cfg_size` into the size register chosen by `cfg_idx`. Index 0 is port A device 1, index 1 is port A device 2, index 2 is port B device 1 and index 3 is port B device 2. The new size applies to requests sampled on the following clock edge or later.
- R3: Sizes are counted in 1024-byte units. Region i spans `size_i*1024` bytes.
- R4: Regions are stacked in index order from address 0. The base of region i is the sum of the byte sizes of regions 0 to i-1.
- R5: An address inside region i (base_i <= addr < base_i + size_i*1024) returns `rsp_cs` = i with `rsp_miss` low.
- R6: A region whose size is zero is never selected. The next nonzero region above it starts at that zero region's base.
- R7: `rsp_offset` equals the request address minus the base of the selected region.
- R8: An address at or above the sum of all four byte sizes returns `rsp_miss` high, with `rsp_cs` = 0 and `rsp_offset` = 0.
- R9: When exactly one region has a nonzero size, every address below that size maps to that region's chip select, with the offset equal to the address.
- R10: `rsp_valid` and the other results appear exactly one clock after a cycle with `req_valid` high. `rsp_valid` is low one clock after a cycle with `req_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Size register write strobe |
| cfg_idx | input | 2 | Size register index (0..3 in stacking order) |
| cfg_size | input | SIZE_W | Region size in kilobytes |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | ADDR_W | Flat byte address to decode |
| rsp_valid | output | 1 | Registered result valid |
| rsp_miss | output | 1 | Address lies above all regions |
| rsp_cs | output | 2 | Selected chip-select index |
| rsp_offset | output | ADDR_W | Byte offset inside the selected device |

## Verification
Every decode result is due exactly one clock after its request. A size write takes effect for a request sampled on the next edge. The bench drives inputs on the falling edge. It reads the chip select, offset and miss flag on the falling edge one cycle later, after exactly one rising edge has passed. Size writes are always completed one full cycle before the next request. After each request the bench waits one idle cycle and checks that `rsp_valid` has dropped. This confirms the one-cycle valid timing in both directions.

// File: rtl/flash_region_decode.sv
module flash_region_decode #(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 32,
  parameter int KB_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_idx,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_miss,
  output logic [1:0]        rsp_cs,
  output logic [ADDR_W-1:0] rsp_offset
);

  localparam int NREG  = 4;
  localparam int LIM_W = SIZE_W + KB_SHIFT + 2;

  logic [NREG-1:0][SIZE_W-1:0] size_q;
  logic [NREG:0][LIM_W-1:0]    edge_b;
  logic [NREG-1:0]             hit;
  logic [LIM_W-1:0]            addr_x;
  logic [1:0]                  sel;
  logic                        miss;
  logic [LIM_W-1:0]            sel_base;

  always_ff @(posedge clk) begin
    if (!rst_n) size_q <= '0;
    else if (cfg_we) size_q[cfg_idx] <= cfg_size;
  end

  assign addr_x    = LIM_W'(req_addr);
  assign edge_b[0] = '0;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign edge_b[i+1] = edge_b[i] + (LIM_W'(size_q[i]) << KB_SHIFT);
    assign hit[i]      = (addr_x >= edge_b[i]) && (addr_x < edge_b[i+1]);
  end

  always_comb begin
    sel = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (hit[i]) sel = 2'(i);
  end

  assign miss     = (hit == '0);
  assign sel_base = edge_b[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_miss   <= 1'b1;
      rsp_cs     <= '0;
      rsp_offset <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_miss   <= miss;
      rsp_cs     <= miss ? 2'd0 : sel;
      rsp_offset <= miss ? '0 : ADDR_W'(addr_x - sel_base);
    end
  end

  logic [NREG-1:0][SIZE_W-1:0] size_seen;
  always_ff @(posedge clk) size_seen <= size_q;

  // R10
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R8
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_cs == 2'd0 && rsp_offset == '0));

  // R6
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_miss) |-> (size_seen[rsp_cs] != '0));

  // R7
  offset_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_miss) |->
      (LIM_W'(rsp_offset) < (LIM_W'(size_seen[rsp_cs]) << KB_SHIFT)));

endmodule

// File: tb/tb_flash_region_decode.sv
module tb_flash_region_decode;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_idx;
  logic [31:0] cfg_size;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        rsp_valid, rsp_miss;
  logic [1:0]  rsp_cs;
  logic [31:0] rsp_offset;

  int nchk = 0;
  int nbad = 0;
  longint msize [4];

  always #5 clk = ~clk;

  flash_region_decode dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_size(cfg_size), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_cs(rsp_cs),
    .rsp_offset(rsp_offset));

  function automatic longint total_bytes();
    longint t = 0;
    for (int i = 0; i < 4; i++) t += msize[i] * 1024;
    return t;
  endfunction

  function automatic void expect_of(input longint a, output bit miss,
                                    output int cs, output longint off);
    longint base = 0;
    miss = 1'b1; cs = 0; off = 0;
    for (int i = 0; i < 4; i++) begin
      if (miss && a >= base && a < base + msize[i] * 1024) begin
        miss = 1'b0; cs = i; off = a - base;
      end
      base += msize[i] * 1024;
    end
  endfunction

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_size(input int idx, input longint kb);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_size = 32'(kb);
    msize[idx] = kb;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input longint a, input string req);
    bit m; int cs; longint off;
    expect_of(a, m, cs, off);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'(a);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R10 valid"}, rsp_valid === 1'b1, longint'(rsp_valid), 1);
    check({req, " R8 miss"}, rsp_miss === m, longint'(rsp_miss), longint'(m));
    check({req, " R5 cs"}, rsp_cs === 2'(cs), longint'(rsp_cs), longint'(cs));
    check({req, " R7 offset"}, rsp_offset === 32'(off), longint'(rsp_offset), off);
    @(negedge clk);
    check("R10 valid drop", rsp_valid === 1'b0, longint'(rsp_valid), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nbad++; nchk++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    longint t;
    void'($urandom(32'd1357));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_size = '0;
    req_valid = 1'b0; req_addr = '0;
    for (int i = 0; i < 4; i++) msize[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 valid low after reset", rsp_valid === 1'b0, longint'(rsp_valid), 0);
    lookup(0, "R1 unconfigured");
    lookup(32'h1234, "R1 unconfigured");

    // R9 single region, port B device 1, 64 KB
    set_size(2, 64);
    lookup(0, "R9 low");
    lookup(65535, "R9 top");
    lookup(65536, "R8 just above");

    // R4 R6 stacking with zero-size hole at index 1
    set_size(0, 4);
    set_size(3, 8);
    lookup(4095, "R4 end of r0");
    lookup(4096, "R6 skip to r2 base");
    lookup(4096 + 65536, "R4 r3 base");
    lookup(4096 + 65536 + 8191, "R4 r3 top");
    lookup(4096 + 65536 + 8192, "R8 above all");

    // R3 R2 large size, index 1
    set_size(0, 0); set_size(2, 0); set_size(3, 0);
    set_size(1, 32'h003F_FFFF);
    lookup(32'hFFFF_FBFF, "R3 large top");
    lookup(32'hFFFF_FC00, "R8 large miss");

    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 4; i++)
        set_size(i, ($urandom_range(3, 0) == 0) ? 0 : $urandom_range(2048, 1));
      t = total_bytes();
      for (int k = 0; k < 40; k++) begin
        longint a;
        a = longint'($urandom_range(32'(t + t / 4 + 1), 0));
        lookup(a, "R5 random");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule